// File: doc/BRIEF.md
# Countdown Event Timer with Gated Control

This block is a one-shot event timer. Software writes a tick count into a value register. That write loads a down-counter and starts it at once. The counter loses one tick per clock while the timer runs. When it runs out, it latches an interrupt-pending flag and stops at zero. It never reloads.

A run-enable bit in the control register gates every side effect:
- counting;
- acceptance of a new tick count;
- clearing of the pending flag.

The interrupt line is the pending flag masked by a separate interrupt-enable bit. A typical driver arms an event in three writes: set run-enable, write the tick count, then set run-enable and interrupt-enable together. It acknowledges an event by writing run-enable together with the clear bit.

Access is through a minimal register port: a write strobe, a byte address and write data, with a read path that returns data in the same cycle from the address alone. The asynchronous active-low reset is released on the clock through a short synchronizer.

Top module: `sys_event_timer`

## Requirements
- R1: While reset is asserted, and after it is released, the control register reads 0, the value register reads 0 and the interrupt output is low.
- R2: The control register is at byte address 0x40: bit 0 is run-enable, bit 1 is interrupt-enable, and bit 4 is a write-only clear strobe. A read returns bits 0 and 1 as written, with bit 4 and all other bits at 0. The value register is at 0x44. Any other address reads 0 and ignores writes.
- R3: A write to 0x44 while run-enable is 1 loads the written count on that clock edge. Reading 0x44 returns the remaining count, which falls by one on every later edge at which run-enable is 1.
- R4: A write to 0x44 while run-enable is 0 is ignored, and the remaining count is unchanged.
- R5: On the edge at which a count of 1 (or a loaded 0) is consumed with run-enable at 1, the count becomes 0 and the pending flag is set. The count then stays at 0 with no reload. The interrupt output is pending AND interrupt-enable.
- R6: A control write with bit 4 set clears pending only if run-enable was already 1 before that write. Otherwise pending is unchanged, including when the same write sets run-enable.
- R7: Clearing run-enable freezes the count. Setting it again resumes the countdown from the frozen value, with the first decrement on the edge after the enabling write.
- R8: Writing 0 to the control register stops counting, drives the interrupt output low and makes the control register read 0.
- R9: A write of a new count while counting restarts from the new value. A loaded count of 1 or 0 expires on the next enabled edge.
- R10: If an expiry and an enabled clear land on the same edge, pending ends up set.
- R11: Pending is latched regardless of interrupt-enable. Setting interrupt-enable later raises the interrupt output for an event that is already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous reset, active low, released synchronously inside |
| bus_we_i | input | 1 | Register write strobe, sampled on the rising edge |
| bus_addr_i | input | ADDR_W | Byte address for reads and writes |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Interrupt, pending AND interrupt-enable |

## Verification
The bench builds the timer with its default parameters: a 32-bit counter, 8-bit addresses and the control and value registers at 0x40 and 0x44. With these, a write of all ones to the control register shows that bits outside the two enables read back as zero. Loads of a few ticks bring expiry, pause and resume, restart, and the clash of an expiry with a clear within reach of a short run. Each of these lands on an edge the bench picks by counting the clock edges from its own writes.

// File: rtl/systmr_pkg.sv
`timescale 1ns/1ps
package systmr_pkg;

  // Control word bit positions (software-visible encoding)
  localparam int unsigned RUN_BIT = 0;
  localparam int unsigned IEN_BIT = 1;
  localparam int unsigned CLR_BIT = 4;

  typedef struct packed {
    logic run;
    logic ien;
  } ctl_t;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTL  = 2'd1,
    SEL_VAL  = 2'd2
  } sel_e;

endpackage

// File: rtl/systmr_rst_sync.sv
`timescale 1ns/1ps
module systmr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES:0]   chain_ext;

  assign chain_ext = {chain_q, 1'b1};

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_ext[STAGES-1:0];
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/systmr_regs.sv
`timescale 1ns/1ps
module systmr_regs
  import systmr_pkg::*;
#(
  parameter int unsigned          DATA_W = 32,
  parameter int unsigned          ADDR_W = 8,
  parameter logic [ADDR_W-1:0]    CTL_A  = 8'h40,
  parameter logic [ADDR_W-1:0]    VAL_A  = 8'h44
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic [DATA_W-1:0] cnt_i,
  output ctl_t              ctl_o,
  output logic              load_o,
  output logic [DATA_W-1:0] load_val_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);

  sel_e sel;
  ctl_t ctl_q, ctl_d;
  logic ctl_we;

  // Address decode
  always_comb begin
    if (bus_addr_i == CTL_A)      sel = SEL_CTL;
    else if (bus_addr_i == VAL_A) sel = SEL_VAL;
    else                          sel = SEL_NONE;
  end

  assign ctl_we = bus_we_i && (sel == SEL_CTL);

  // Control next state
  always_comb begin
    ctl_d = ctl_q;
    if (ctl_we) begin
      ctl_d.run = bus_wdata_i[RUN_BIT];
      ctl_d.ien = bus_wdata_i[IEN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_d;
  end

  // Side effects are gated by the run bit held before this write
  assign load_o     = bus_we_i && (sel == SEL_VAL) && ctl_q.run;
  assign load_val_o = bus_wdata_i;
  assign clr_o      = ctl_we && bus_wdata_i[CLR_BIT] && ctl_q.run;
  assign ctl_o      = ctl_q;

  // Read mux
  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CTL: begin
        rdata_o[RUN_BIT] = ctl_q.run;
        rdata_o[IEN_BIT] = ctl_q.ien;
      end
      SEL_VAL:  rdata_o = cnt_i;
      default:  rdata_o = '0;
    endcase
  end

endmodule

// File: rtl/systmr_count.sv
`timescale 1ns/1ps
module systmr_count #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             armed_q, armed_d;
  logic             tick, last, upd;

  assign tick     = armed_q && run_i;
  assign last     = (cnt_q[CNT_W-1:1] == '0);
  assign expire_o = tick && last && !load_i;
  assign upd      = load_i || tick;

  always_comb begin
    cnt_d   = cnt_q;
    armed_d = armed_q;
    if (load_i) begin
      cnt_d   = load_val_i;
      armed_d = 1'b1;
    end else if (tick) begin
      if (last) begin
        cnt_d   = '0;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (upd) begin
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/systmr_flag.sv
`timescale 1ns/1ps
module systmr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic expire_i,
  input  logic clr_i,
  input  logic ien_i,
  output logic pend_o,
  output logic irq_o
);

  logic pend_q, pend_d, pend_en;

  assign pend_en = expire_i || clr_i;

  // A new event takes priority over an acknowledge on the same edge
  always_comb begin
    pend_d = pend_q;
    if (expire_i)   pend_d = 1'b1;
    else if (clr_i) pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign pend_o = pend_q;
  assign irq_o  = pend_q && ien_i;

endmodule

// File: rtl/sys_event_timer.sv
`timescale 1ns/1ps
module sys_event_timer
  import systmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned CTL_OFFSET  = 'h40,
  parameter int unsigned VAL_OFFSET  = 'h44,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              arst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o
);

  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFFSET);
  localparam logic [ADDR_W-1:0] VAL_A = ADDR_W'(VAL_OFFSET);

  logic             rst_sync_n;
  ctl_t             ctl;
  logic             run_en, irq_en;
  logic             load, clr, expire, pend;
  logic [CNT_W-1:0] load_val, cnt;

  systmr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (arst_ni),
    .rst_no  (rst_sync_n)
  );

  systmr_regs #(
    .DATA_W (CNT_W),
    .ADDR_W (ADDR_W),
    .CTL_A  (CTL_A),
    .VAL_A  (VAL_A)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .cnt_i       (cnt),
    .ctl_o       (ctl),
    .load_o      (load),
    .load_val_o  (load_val),
    .clr_o       (clr),
    .rdata_o     (bus_rdata_o)
  );

  assign run_en = ctl.run;
  assign irq_en = ctl.ien;

  systmr_count #(.CNT_W(CNT_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .run_i      (run_en),
    .load_i     (load),
    .load_val_i (load_val),
    .cnt_o      (cnt),
    .expire_o   (expire)
  );

  systmr_flag u_flag (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .expire_i (expire),
    .clr_i    (clr),
    .ien_i    (irq_en),
    .pend_o   (pend),
    .irq_o    (irq_o)
  );

endmodule

// File: rtl/sys_event_timer_chk.sv
`timescale 1ns/1ps
module sys_event_timer_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_i,
  input logic             ien_i,
  input logic             load_i,
  input logic [CNT_W-1:0] load_val_i,
  input logic             clr_i,
  input logic             expire_i,
  input logic             pend_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             irq_i
);

  AST_LOAD_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_i == $past(load_val_i)); // R3

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(cnt_i)); // R7

  AST_EXPIRY_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> (pend_i && cnt_i == '0)); // R5

  AST_NO_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !load_i) |=> cnt_i == '0); // R5

  AST_CLR_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && pend_i) |=> pend_i); // R6

  AST_CLR_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !expire_i) |=> !pend_i); // R6

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && expire_i) |=> pend_i); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ien_i |-> !irq_i); // R11

endmodule

bind sys_event_timer sys_event_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_sync_n),
  .run_i      (run_en),
  .ien_i      (irq_en),
  .load_i     (load),
  .load_val_i (load_val),
  .clr_i      (clr),
  .expire_i   (expire),
  .pend_i     (pend),
  .cnt_i      (cnt),
  .irq_i      (irq_o)
);

// File: tb/sys_event_timer_bench.sv
`timescale 1ns/1ps
module sys_event_timer_bench;

  localparam logic [7:0] A_CTL  = 8'h40;
  localparam logic [7:0] A_VAL  = 8'h44;
  localparam logic [7:0] A_NONE = 8'h48;

  logic        clk = 1'b0;
  logic        arst_n;
  logic        we;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  sys_event_timer u_sys_event_timer (
    .clk_i       (clk),
    .arst_ni     (arst_n),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference model
  bit        m_run, m_ien, m_pend, m_armed;
  bit [31:0] m_cnt;

  function automatic bit [31:0] m_read(input logic [7:0] a);
    if (a == A_CTL) return {30'd0, m_ien, m_run};
    if (a == A_VAL) return m_cnt;
    return 32'd0;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_run = 0; m_ien = 0; m_pend = 0; m_armed = 0; m_cnt = 0;
    end else begin
      bit wc, wv, ld, tk, ex, cl;
      wc = we && addr == A_CTL;
      wv = we && addr == A_VAL;
      ld = wv && m_run;
      tk = m_armed && m_run;
      ex = tk && (m_cnt <= 1) && !ld;
      cl = wc && wdata[4] && m_run;
      if (ld) begin
        m_cnt = wdata; m_armed = 1;
      end else if (tk) begin
        if (m_cnt <= 1) begin m_cnt = 0; m_armed = 0; end
        else m_cnt = m_cnt - 1;
      end
      if (ex) m_pend = 1;
      else if (cl) m_pend = 0;
      if (wc) begin m_run = wdata[0]; m_ien = wdata[1]; end
    end
  end

  // Per-cycle comparison, away from the edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk((addr == A_CTL) ? "R2 ctl read" : "R3 read", rdata, m_read(addr));
      chk("R5 irq", {31'd0, irq}, {31'd0, m_pend && m_ien});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    addr = a; #1;
    chk(tag, rdata, exp);
  endtask

  task automatic irq_chk(input string tag, input logic exp);
    #1;
    chk(tag, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    arst_n = 1'b0; we = 1'b0; addr = A_CTL; wdata = '0;
    #1;
    rd_chk("R1 ctl in reset", A_CTL, 32'd0);
    rd_chk("R1 val in reset", A_VAL, 32'd0);
    irq_chk("R1 irq in reset", 1'b0);
    idle(3); arst_n = 1'b1; idle(4);
    rd_chk("R1 ctl after reset", A_CTL, 32'd0);
    rd_chk("R1 val after reset", A_VAL, 32'd0);

    // R2: enable bits read back, clear strobe reads 0
    wr(A_CTL, 32'h3);
    rd_chk("R2 ctl readback", A_CTL, 32'h3);
    wr(A_CTL, 32'h13);
    rd_chk("R2 clr bit reads 0", A_CTL, 32'h3);

    // R3: load and count down
    wr(A_VAL, 32'd10);
    rd_chk("R3 loaded", A_VAL, 32'd10);
    idle(3);
    rd_chk("R3 decrement", A_VAL, 32'd7);

    // R7: pause freezes count
    wr(A_CTL, 32'h2);
    rd_chk("R7 frozen value", A_VAL, 32'd5);
    wr(A_VAL, 32'd99);
    rd_chk("R4 write ignored when off", A_VAL, 32'd5);
    idle(5);
    rd_chk("R7 held while off", A_VAL, 32'd5);
    wr(A_CTL, 32'h3);
    rd_chk("R7 resume no step yet", A_VAL, 32'd5);
    idle(2);
    rd_chk("R7 resumed", A_VAL, 32'd3);

    // R5: expiry
    wr(A_VAL, 32'd5);
    idle(4);
    rd_chk("R5 one left", A_VAL, 32'd1);
    irq_chk("R5 not yet", 1'b0);
    idle(1);
    rd_chk("R5 reached zero", A_VAL, 32'd0);
    irq_chk("R5 irq raised", 1'b1);
    idle(3);
    rd_chk("R5 no reload", A_VAL, 32'd0);
    irq_chk("R5 stays pending", 1'b1);

    // R6: clear gated by prior run bit
    wr(A_CTL, 32'h2);
    irq_chk("R6 pending kept", 1'b1);
    wr(A_CTL, 32'h12);
    irq_chk("R6 clear ignored off", 1'b1);
    wr(A_CTL, 32'h13);
    irq_chk("R6 clear ignored same write", 1'b1);
    wr(A_CTL, 32'h13);
    irq_chk("R6 clear with run", 1'b0);

    // R11: pending latched while masked
    wr(A_CTL, 32'h1);
    wr(A_VAL, 32'd3);
    idle(3);
    rd_chk("R11 expired masked", A_VAL, 32'd0);
    irq_chk("R11 masked", 1'b0);
    wr(A_CTL, 32'h3);
    irq_chk("R11 unmask shows event", 1'b1);
    wr(A_CTL, 32'h13);

    // R9: restart and short loads
    wr(A_VAL, 32'd20);
    idle(2);
    rd_chk("R9 running", A_VAL, 32'd18);
    wr(A_VAL, 32'd4);
    rd_chk("R9 restarted", A_VAL, 32'd4);
    idle(3);
    irq_chk("R9 not yet", 1'b0);
    idle(1);
    irq_chk("R9 restart expiry", 1'b1);
    wr(A_CTL, 32'h13);
    wr(A_VAL, 32'd1);
    rd_chk("R9 load one", A_VAL, 32'd1);
    irq_chk("R9 load one no irq", 1'b0);
    idle(1);
    irq_chk("R9 one expires", 1'b1);
    wr(A_CTL, 32'h13);
    wr(A_VAL, 32'd0);
    irq_chk("R9 load zero no irq", 1'b0);
    idle(1);
    irq_chk("R9 zero expires", 1'b1);
    wr(A_CTL, 32'h13);

    // R10: expiry and clear on the same edge
    wr(A_VAL, 32'd2);
    wr(A_CTL, 32'h13);
    irq_chk("R10 set wins", 1'b1);
    rd_chk("R10 count zero", A_VAL, 32'd0);
    wr(A_CTL, 32'h13);

    // R8: write 0 disables
    wr(A_VAL, 32'd9);
    wr(A_CTL, 32'h0);
    rd_chk("R8 ctl zero", A_CTL, 32'd0);
    idle(4);
    rd_chk("R8 count stopped", A_VAL, 32'd7);
    irq_chk("R8 irq low", 1'b0);

    // R2: other bits and unmapped address
    wr(A_CTL, 32'hFFFF_FFFF);
    rd_chk("R2 only enables read back", A_CTL, 32'h3);
    wr(A_NONE, 32'h55);
    rd_chk("R2 unmapped reads 0", A_NONE, 32'd0);
    wr(A_CTL, 32'h0);

    // R1: reset during a run
    wr(A_CTL, 32'h3);
    wr(A_VAL, 32'd50);
    arst_n = 1'b0;
    rd_chk("R1 val after mid reset", A_VAL, 32'd0);
    rd_chk("R1 ctl after mid reset", A_CTL, 32'd0);
    irq_chk("R1 irq after mid reset", 1'b0);
    idle(2); arst_n = 1'b1; idle(4);
    rd_chk("R1 val after release", A_VAL, 32'd0);

    finish_run();
  end

endmodule